// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block takes a 32-bit single-precision floating-point value and produces a 16-bit half-precision value. A set of control inputs travels with each operand and selects the behaviour. They choose one of four rounding directions. They can flush single subnormal operands to zero. They can replace every quiet NaN result with one fixed NaN. They can switch the output to an alternative half format. That format has no infinities or NaNs and gives up those codes to extend the normal range by one binade.

Along with the result, the block reports which floating-point exceptions the conversion raised. Each exception has an enable bit. An enabled exception is not recorded in the status output; instead the block raises a single trap request. Operands are accepted on any cycle marked valid. The result, status and trap request appear together, registered, one cycle later.

Top module: `sp_to_hp_narrow`

## Requirements
- R1: `rnd_mode` selects the rounding direction: 0 is nearest with ties to even, 1 rounds toward +infinity, 2 rounds toward -infinity, and 3 rounds toward zero. The directed modes round the magnitude up on any nonzero discarded part, but only for results of their own sign.
- R2: With `flush_zero` set, a subnormal single operand becomes a zero of the same sign and raises input-denormal (status bit 7) and nothing else.
- R3: Results below the smallest half normal exponent (-14) are shifted into subnormal form before rounding, and 10 fraction bits are kept.
- R4: A rounding carry that takes a subnormal to 2^10 produces the smallest normal (biased exponent 1). A carry that takes the significand to 2^11 increments the exponent and halves the significand.
- R5: Underflow (bit 3) is raised when the biased exponent before rounding is 0 and the result is inexact, or whenever `trap_en[3]` is set.
- R6: Any nonzero discarded part raises inexact (bit 4), including for subnormal single operands that are not flushed.
- R7: With `alt_half` clear, a biased exponent of 31 or more is an overflow, which raises overflow (bit 2) and inexact. The result is signed infinity (0x7C00/0xFC00) in mode 0, in mode 1 when positive and in mode 2 when negative. In every other case the result is signed max-normal (0x7BFF/0xFBFF).
- R8: With `alt_half` set, biased exponent 31 is a normal result. Only 32 or more saturates, giving sign|0x7FFF and raising invalid (bit 0) without overflow or inexact.
- R9: With `alt_half` set, a NaN operand gives a signed zero and an infinity gives sign|0x7FFF. Both raise invalid.
- R10: With `alt_half` clear, a NaN gives 0x7E00 if `default_nan` is set. Otherwise it gives sign|0x7E00|operand bits 21:13. Invalid is raised only for a signaling NaN (operand bit 22 clear).
- R11: Status bits are 0 invalid, 2 overflow, 3 underflow, 4 inexact and 7 input-denormal. A raised exception whose `trap_en` bit at the same position is set drives `out_trap` high instead of setting its status bit.
- R12: Signed zeros map to 0x0000/0x8000 and, with `alt_half` clear, infinities map to 0x7C00/0xFC00, all with no status and no trap.
- R13: `out_valid` rises exactly one cycle after `in_valid` and is low otherwise, and reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| in_single | input | 32 | Single-precision operand |
| rnd_mode | input | 2 | Rounding direction |
| flush_zero | input | 1 | Treat subnormal operands as zero |
| default_nan | input | 1 | Replace NaN results with the fixed NaN |
| alt_half | input | 1 | Use the alternative half format |
| trap_en | input | 8 | Per-exception trap enables, bit i for status bit i |
| out_valid | output | 1 | Result registers loaded last cycle |
| out_half | output | 16 | Half-precision result |
| out_flags | output | 8 | Exceptions raised and not trapped |
| out_trap | output | 1 | At least one raised exception was enabled |

## Verification
Every result, status bit and trap request is due in the single cycle after the operand is presented. The bench drives each operand on a falling edge and samples all outputs on the next falling edge, just after the capturing rising edge. It checks the valid strobe in that same window. It then drops `in_valid` and confirms the strobe falls one cycle later, so no check can pass on a value left over from an earlier operand.

// File: rtl/sp_to_hp_narrow.sv
module sp_to_hp_narrow (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_single,
  input  logic [1:0]  rnd_mode,
  input  logic        flush_zero,
  input  logic        default_nan,
  input  logic        alt_half,
  input  logic [7:0]  trap_en,
  output logic        out_valid,
  output logic [15:0] out_half,
  output logic [7:0]  out_flags,
  output logic        out_trap
);
  localparam int SE_W = 8;
  localparam int SF_W = 23;
  localparam int HE_W = 5;
  localparam int HF_W = 10;
  localparam int BIAS_GAP = 112;
  localparam int GRS_W = 2 * (SF_W + 1) - HF_W - 2;
  localparam int MAX_DROP = SF_W - HF_W - 1;

  localparam int X_INV = 0;
  localparam int X_OVF = 2;
  localparam int X_UNF = 3;
  localparam int X_INX = 4;
  localparam int X_DEN = 7;

  logic            sgn;
  logic [SE_W-1:0] ex;
  logic [SF_W-1:0] fr;
  assign sgn = in_single[31];
  assign ex  = in_single[30:23];
  assign fr  = in_single[22:0];

  logic exp_zero, exp_ones, frac_nz;
  assign exp_zero = (ex == '0);
  assign exp_ones = (ex == '1);
  assign frac_nz  = |fr;

  logic c_zero, c_inden, c_sub, c_inf, c_nan, c_snan;
  assign c_zero  = exp_zero && (!frac_nz || flush_zero);
  assign c_inden = exp_zero && frac_nz && flush_zero;
  assign c_sub   = exp_zero && frac_nz && !flush_zero;
  assign c_inf   = exp_ones && !frac_nz;
  assign c_nan   = exp_ones && frac_nz;
  assign c_snan  = c_nan && !fr[SF_W-1];

  logic [SF_W:0] sig;
  assign sig = {!exp_zero, fr};

  logic signed [9:0] eh;
  assign eh = $signed({2'b00, ex}) - 10'sd112;

  logic [3:0] drop;
  always_comb begin
    if (c_sub || eh <= -10'sd11) drop = 4'(MAX_DROP);
    else if (eh >= 10'sd1)       drop = 4'd0;
    else                         drop = 4'(10'sd1 - eh);
  end

  logic [GRS_W-1:0] wide;
  assign wide = {sig, {(GRS_W-SF_W-1){1'b0}}} >> drop;

  logic [HF_W:0] trunc;
  logic          rbit, stk, inx;
  assign trunc = wide[GRS_W-1 -: HF_W+1];
  assign rbit  = wide[GRS_W-HF_W-2];
  assign stk   = |wide[GRS_W-HF_W-3:0];
  assign inx   = rbit | stk;

  logic [SE_W-1:0] be0;
  assign be0 = (eh >= 10'sd1) ? SE_W'(eh) : '0;

  logic rup, to_inf;
  always_comb begin
    case (rnd_mode)
      2'd0:    begin rup = rbit && (stk || trunc[0]); to_inf = 1'b1; end
      2'd1:    begin rup = inx && !sgn;               to_inf = !sgn; end
      2'd2:    begin rup = inx && sgn;                to_inf = sgn;  end
      default: begin rup = 1'b0;                      to_inf = 1'b0; end
    endcase
  end

  logic [HF_W+1:0] sum;
  assign sum = {1'b0, trunc} + {{(HF_W+1){1'b0}}, rup};

  logic [SE_W-1:0] be1, be2;
  logic [HF_W-1:0] man;
  always_comb begin
    be1 = (rup && sum == (HF_W+2)'(1 << HF_W)) ? SE_W'(1) : be0;
    if (sum[HF_W+1]) begin
      be2 = be1 + SE_W'(1);
      man = sum[HF_W:1];
    end else begin
      be2 = be1;
      man = sum[HF_W-1:0];
    end
  end

  logic ieee_ovf, ahp_ovf, unf;
  assign ieee_ovf = (be2 >= SE_W'(31));
  assign ahp_ovf  = (be2 >= SE_W'(32));
  assign unf      = (be0 == '0) && (inx || trap_en[X_UNF]);

  logic [15:0] res;
  logic [7:0]  exc;
  always_comb begin
    res = {sgn, be2[HE_W-1:0], man};
    exc = '0;
    if (c_nan) begin
      if (alt_half)         res = {sgn, 15'h0000};
      else if (default_nan) res = 16'h7E00;
      else                  res = {sgn, 6'b111111, fr[21:13]};
      exc[X_INV] = c_snan || alt_half;
    end else if (c_inf) begin
      if (alt_half) begin
        res = {sgn, 15'h7FFF};
        exc[X_INV] = 1'b1;
      end else begin
        res = {sgn, 15'h7C00};
      end
    end else if (c_zero) begin
      res = {sgn, 15'h0000};
      exc[X_DEN] = c_inden;
    end else begin
      exc[X_UNF] = unf;
      exc[X_INX] = inx;
      if (!alt_half && ieee_ovf) begin
        res = to_inf ? {sgn, 15'h7C00} : {sgn, 15'h7BFF};
        exc[X_OVF] = 1'b1;
        exc[X_INX] = 1'b1;
      end else if (alt_half && ahp_ovf) begin
        res = {sgn, 15'h7FFF};
        exc[X_INV] = 1'b1;
        exc[X_INX] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_half  <= '0;
      out_flags <= '0;
      out_trap  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_half  <= res;
        out_flags <= exc & ~trap_en;
        out_trap  <= |(exc & trap_en);
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R13
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R13
  AST_FZ_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && flush_zero && in_single[30:23] == 8'd0 && in_single[22:0] != 23'd0)
    |=> (out_half[14:0] == 15'd0)); // R2
  AST_AHP_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && alt_half) |=> !out_flags[2]); // R8
  AST_TRAP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_flags & $past(trap_en)) == 8'd0)); // R11
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_single[30:0] == 31'd0)
    |=> (out_half == {$past(in_single[31]), 15'd0} && out_flags == 8'd0 && !out_trap)); // R12
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !alt_half && trap_en == 8'd0) |=> (!out_flags[2] || out_flags[4])); // R7
  AST_DEFAULT_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !alt_half && default_nan && in_single[30:23] == 8'hFF && in_single[22:0] != 23'd0)
    |=> (out_half == 16'h7E00)); // R10
endmodule

// File: tb/sp_to_hp_narrow_bench.sv
module sp_to_hp_narrow_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_single = '0;
  logic [1:0]  rnd_mode = '0;
  logic        flush_zero = 1'b0;
  logic        default_nan = 1'b0;
  logic        alt_half = 1'b0;
  logic [7:0]  trap_en = '0;
  logic        out_valid;
  logic [15:0] out_half;
  logic [7:0]  out_flags;
  logic        out_trap;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  sp_to_hp_narrow u_sp_to_hp_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_single(in_single),
    .rnd_mode(rnd_mode), .flush_zero(flush_zero), .default_nan(default_nan),
    .alt_half(alt_half), .trap_en(trap_en), .out_valid(out_valid),
    .out_half(out_half), .out_flags(out_flags), .out_trap(out_trap)
  );

  // {mode, fz, dn, ahp, trap_en, operand, half, flags, trap}
  localparam int NV = 42;
  localparam logic [69:0] VEC [NV] = '{
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h3F800000,16'h3C00,8'h00,1'b0}, // R12 one
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'hC0000000,16'hC000,8'h00,1'b0}, // R12 minus two
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h00000000,16'h0000,8'h00,1'b0}, // R12 +0
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h80000000,16'h8000,8'h00,1'b0}, // R12 -0
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h7F800000,16'h7C00,8'h00,1'b0}, // R12 +inf
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'hFF800000,16'hFC00,8'h00,1'b0}, // R12 -inf
    {2'd0,1'b0,1'b0,1'b1,8'h00,32'hFF800000,16'hFFFF,8'h01,1'b0}, // R9 alt inf
    {2'd0,1'b0,1'b0,1'b1,8'h00,32'hFFC00000,16'h8000,8'h01,1'b0}, // R9 alt NaN
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h7FC00000,16'h7E00,8'h00,1'b0}, // R10 qNaN
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'hFFC02000,16'hFE01,8'h00,1'b0}, // R10 payload
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h7F802000,16'h7E01,8'h01,1'b0}, // R10 sNaN
    {2'd0,1'b0,1'b1,1'b0,8'h00,32'hFFC02000,16'h7E00,8'h00,1'b0}, // R10 default qNaN
    {2'd0,1'b0,1'b1,1'b0,8'h00,32'h7F802000,16'h7E00,8'h01,1'b0}, // R10 default sNaN
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h3F801000,16'h3C00,8'h10,1'b0}, // R1 tie to even
    {2'd1,1'b0,1'b0,1'b0,8'h00,32'h3F801000,16'h3C01,8'h10,1'b0}, // R1 up
    {2'd3,1'b0,1'b0,1'b0,8'h00,32'h3F801000,16'h3C00,8'h10,1'b0}, // R1 zero
    {2'd2,1'b0,1'b0,1'b0,8'h00,32'h3F801000,16'h3C00,8'h10,1'b0}, // R1 down pos
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h3F803000,16'h3C02,8'h10,1'b0}, // R1 tie odd
    {2'd2,1'b0,1'b0,1'b0,8'h00,32'hBF801000,16'hBC01,8'h10,1'b0}, // R1 down neg
    {2'd1,1'b0,1'b0,1'b0,8'h00,32'hBF801000,16'hBC00,8'h10,1'b0}, // R1 up neg
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h3FFFF000,16'h4000,8'h10,1'b0}, // R4 carry 2^11
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h477FF000,16'h7C00,8'h14,1'b0}, // R7 round to inf
    {2'd3,1'b0,1'b0,1'b0,8'h00,32'h477FF000,16'h7BFF,8'h10,1'b0}, // R7 zero no ovf
    {2'd1,1'b0,1'b0,1'b0,8'h00,32'hD0000000,16'hFBFF,8'h14,1'b0}, // R7 up neg max
    {2'd2,1'b0,1'b0,1'b0,8'h00,32'hD0000000,16'hFC00,8'h14,1'b0}, // R7 down neg inf
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h47800000,16'h7C00,8'h14,1'b0}, // R7 exact 2^16
    {2'd0,1'b0,1'b0,1'b1,8'h00,32'h477FF000,16'h7C00,8'h10,1'b0}, // R8 alt exp 31
    {2'd0,1'b0,1'b0,1'b1,8'h00,32'h47800000,16'h7C00,8'h00,1'b0}, // R8 alt 2^16
    {2'd0,1'b0,1'b0,1'b1,8'h00,32'h50000000,16'h7FFF,8'h01,1'b0}, // R8 alt sat
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h33800000,16'h0001,8'h00,1'b0}, // R3 2^-24
    {2'd0,1'b0,1'b0,1'b0,8'h08,32'h33800000,16'h0001,8'h00,1'b1}, // R5 forced unf
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h33000000,16'h0000,8'h18,1'b0}, // R3 2^-25 tie
    {2'd1,1'b0,1'b0,1'b0,8'h00,32'h33000000,16'h0001,8'h18,1'b0}, // R3 2^-25 up
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h387FE000,16'h0400,8'h18,1'b0}, // R4 sub to normal
    {2'd0,1'b1,1'b0,1'b0,8'h00,32'h00000001,16'h0000,8'h80,1'b0}, // R2 flush pos
    {2'd1,1'b1,1'b0,1'b0,8'h00,32'h80400000,16'h8000,8'h80,1'b0}, // R2 flush neg
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h00000001,16'h0000,8'h18,1'b0}, // R6 tiny
    {2'd1,1'b0,1'b0,1'b0,8'h00,32'h00000001,16'h0001,8'h18,1'b0}, // R6 tiny up
    {2'd0,1'b0,1'b0,1'b0,8'h00,32'h3F802000,16'h3C01,8'h00,1'b0}, // R6 exact
    {2'd0,1'b0,1'b0,1'b0,8'h10,32'h3F801000,16'h3C00,8'h00,1'b1}, // R11 inexact trap
    {2'd0,1'b0,1'b0,1'b0,8'h01,32'h7F802000,16'h7E01,8'h00,1'b1}, // R11 invalid trap
    {2'd0,1'b0,1'b0,1'b0,8'h04,32'h477FF000,16'h7C00,8'h10,1'b1}  // R11 overflow trap
  };
  localparam int VREQ [NV] = '{12,12,12,12,12,12,9,9,10,10,10,10,10,1,1,1,1,1,1,1,
                               4,7,7,7,7,7,8,8,8,3,5,3,3,4,2,2,6,6,6,11,11,11};

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [69:0] v);
    @(negedge clk);
    rnd_mode    = v[69:68];
    flush_zero  = v[67];
    default_nan = v[66];
    alt_half    = v[65];
    trap_en     = v[64:57];
    in_single   = v[56:25];
    in_valid    = 1'b1;
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(13, "reset valid", 32'(out_valid), 32'd0);
    chk(13, "reset half", 32'(out_half), 32'd0);
    chk(13, "reset flags/trap", 32'({out_flags, out_trap}), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      chk(13, "valid strobe", 32'(out_valid), 32'd1);
      chk(VREQ[i], $sformatf("vec %0d half", i), 32'(out_half), 32'(VEC[i][24:9]));
      chk(VREQ[i], $sformatf("vec %0d flags", i), 32'(out_flags), 32'(VEC[i][8:1]));
      chk(VREQ[i], $sformatf("vec %0d trap", i), 32'(out_trap), 32'(VEC[i][0]));
      in_valid = 1'b0;
    end

    // R13: strobe drops one cycle after in_valid falls
    @(negedge clk);
    chk(13, "idle valid", 32'(out_valid), 32'd0);

    // R13: back-to-back operands, each due one cycle later
    drive(VEC[0]);
    @(negedge clk);
    chk(13, "b2b first", 32'(out_half), 32'h3C00);
    rnd_mode = 2'd1; in_single = 32'h3F801000; trap_en = 8'h00;
    @(negedge clk);
    chk(1, "b2b second", 32'(out_half), 32'h3C01);
    chk(13, "b2b valid", 32'(out_valid), 32'd1);
    in_valid = 1'b0;

    // R5: tiny exact result, underflow untrapped without forcing bit
    drive({2'd0,1'b0,1'b0,1'b0,8'h00,32'h33800000,16'h0001,8'h00,1'b0});
    @(negedge clk);
    chk(5, "exact tiny no underflow", 32'(out_flags), 32'd0);
    in_valid = 1'b0;

    // R13: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(13, "re-reset half", 32'(out_half), 32'd0);
    chk(13, "re-reset valid", 32'(out_valid), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule